// File: doc/BRIEF.md
# Runahead Checkpoint Register File

This block is an integer register file in which every register carries a poison flag, together with a one-cycle checkpoint and restore for a runahead execution mode. When a load misses far down the cache hierarchy, the pipeline raises an enter strobe. In that same clock the block copies every register value into shadow storage. It also copies the live branch history value and a small return-address stack, including its top pointer. The pipeline then keeps executing speculatively, only to warm the caches.

While runahead is active, each write carries the poison flags of its two sources and a flag marking an outstanding miss. The stored poison bit is the OR of those three flags, and it is written together with the data. Poison therefore spreads through every instruction that depends on the missing load. When the miss returns, the pipeline raises an exit strobe. In one cycle the block puts back every register and the speculative predictor state and clears all poison bits, much like recovery from a mispredicted branch.

Top module: `rahead_regfile`

## Requirements
- R1: After reset the block is in normal mode (`in_runahead` = 0), every register reads 0 with poison 0, and the branch history, return-address stack and stack pointer outputs are all 0.
- R2: Register index 0 always reads 0 with poison 0 on both read ports. Writes to it have no effect, whatever their flags.
- R3: A write with `wr_en` = 1 appears on either read port from the next cycle. In normal mode the stored poison bit is 0 whatever the flag inputs are.
- R4: An `ra_enter` pulse in normal mode sets `in_runahead` from the next cycle. It saves the register values and the history, stack and pointer as they stood before that cycle's writes. A register or state write in the same cycle still updates the live copy.
- R5: In runahead mode, a write stores poison = `wr_src0_inv` OR `wr_src1_inv` OR `wr_miss`, and the data is stored in the same cycle.
- R6: In runahead mode, a write whose three flags are all 0 clears the poison bit of its destination register.
- R7: An `ra_exit` pulse in runahead mode clears `in_runahead` from the next cycle. From that cycle every register, the history, the stack and the pointer read back their saved values, and every poison bit is 0.
- R8: A register write or a state write made in the same cycle as an effective exit is discarded.
- R9: `ra_enter` during runahead has no effect and does not overwrite the saved copy. `ra_exit` in normal mode has no effect on any state.
- R10: With `st_we` = 1, the live history, stack contents and stack pointer take the state inputs from the next cycle, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd0_idx | input | 5 | Read port 0 register index |
| rd0_data | output | 32 | Read port 0 value |
| rd0_inv | output | 1 | Read port 0 poison bit |
| rd1_idx | input | 5 | Read port 1 register index |
| rd1_data | output | 32 | Read port 1 value |
| rd1_inv | output | 1 | Read port 1 poison bit |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register index |
| wr_data | input | 32 | Write value |
| wr_src0_inv | input | 1 | Producer's first source was poisoned |
| wr_src1_inv | input | 1 | Producer's second source was poisoned |
| wr_miss | input | 1 | Producer is the load that missed |
| ra_enter | input | 1 | Enter runahead strobe |
| ra_exit | input | 1 | Leave runahead strobe |
| in_runahead | output | 1 | Runahead mode active |
| st_we | input | 1 | Live predictor state write enable |
| st_bhr_in | input | 16 | New branch history value |
| st_ras_in | input | 128 | New stack contents, entry k in bits [32k+31:32k] |
| st_top_in | input | 2 | New stack top pointer |
| st_bhr | output | 16 | Live branch history |
| st_ras | output | 128 | Live stack contents, same packing |
| st_top | output | 2 | Live stack top pointer |

## Verification
The bench writes a register in the same cycle as entry. A design that saved the value after the write would restore the speculative value instead of the old one. It also writes registers and predictor state in the exit cycle, which a design that let the restore lose priority would leak into normal mode. Poison is raised through each of its three causes separately and then cleared by a clean write; a design missing one OR term, or keeping stale poison, would report the wrong flag. A second enter during runahead and an exit in normal mode check that neither re-saves nor restores state.

// File: rtl/rahead_pkg.sv
package rahead_pkg;

   typedef enum logic {
      MODE_NORMAL   = 1'b0,
      MODE_RUNAHEAD = 1'b1
   } ra_mode_e;

   // width of an index into a structure of n entries, never below one bit
   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // poison of a result: only meaningful while speculating
   function automatic logic result_poison(input logic src0, input logic src1,
                                          input logic miss, input logic spec);
      return spec & (src0 | src1 | miss);
   endfunction

endpackage

// File: rtl/rahead_mode_ctl.sv
module rahead_mode_ctl
   import rahead_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic enter_i,
   input  logic exit_i,
   output logic spec_o,
   output logic take_ckpt_o,
   output logic restore_o
);

   ra_mode_e mode_q;

   assign spec_o      = (mode_q == MODE_RUNAHEAD);
   assign take_ckpt_o = enter_i && (mode_q == MODE_NORMAL);
   assign restore_o   = exit_i  && (mode_q == MODE_RUNAHEAD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_NORMAL;
      end else if (take_ckpt_o) begin
         mode_q <= MODE_RUNAHEAD;
      end else if (restore_o) begin
         mode_q <= MODE_NORMAL;
      end
   end

endmodule

// File: rtl/rahead_reg_bank.sv
module rahead_reg_bank #(
   parameter int unsigned NREGS     = 32,
   parameter int unsigned XLEN      = 32,
   parameter bit          HARD_ZERO = 1'b1,
   localparam int unsigned IDX_W    = rahead_pkg::idx_width(NREGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [IDX_W-1:0] widx_i,
   input  logic [XLEN-1:0]  wdata_i,
   input  logic             winv_i,
   input  logic             take_ckpt_i,
   input  logic             restore_i,
   output logic [XLEN-1:0]  val_o [NREGS],
   output logic [NREGS-1:0] inv_o
);

   for (genvar g = 0; g < NREGS; g++) begin : g_reg
      if ((g == 0) && HARD_ZERO) begin : g_zero
         assign val_o[g] = '0;
         assign inv_o[g] = 1'b0;
      end else begin : g_live
         logic [XLEN-1:0] live_q;
         logic [XLEN-1:0] shad_q;
         logic            inv_q;
         logic            hit;

         assign hit = we_i && (widx_i == IDX_W'(g));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               live_q <= '0;
               inv_q  <= 1'b0;
            end else if (restore_i) begin
               live_q <= shad_q;
               inv_q  <= 1'b0;
            end else if (hit) begin
               live_q <= wdata_i;
               inv_q  <= winv_i;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               shad_q <= '0;
            end else if (take_ckpt_i) begin
               shad_q <= live_q;
            end
         end

         assign val_o[g] = live_q;
         assign inv_o[g] = inv_q;
      end
   end

endmodule

// File: rtl/rahead_spec_state.sv
module rahead_spec_state #(
   parameter int unsigned BHR_W     = 16,
   parameter int unsigned RA_W      = 32,
   parameter int unsigned RAS_DEPTH = 4,
   localparam int unsigned PTR_W    = rahead_pkg::idx_width(RAS_DEPTH),
   localparam int unsigned STK_W    = RAS_DEPTH * RA_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [BHR_W-1:0] bhr_i,
   input  logic [STK_W-1:0] stk_i,
   input  logic [PTR_W-1:0] ptr_i,
   input  logic             take_ckpt_i,
   input  logic             restore_i,
   output logic [BHR_W-1:0] bhr_o,
   output logic [STK_W-1:0] stk_o,
   output logic [PTR_W-1:0] ptr_o
);

   logic [BHR_W-1:0] bhr_q, bhr_sv;
   logic [PTR_W-1:0] ptr_q, ptr_sv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bhr_q <= '0;
         ptr_q <= '0;
      end else if (restore_i) begin
         bhr_q <= bhr_sv;
         ptr_q <= ptr_sv;
      end else if (we_i) begin
         bhr_q <= bhr_i;
         ptr_q <= ptr_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bhr_sv <= '0;
         ptr_sv <= '0;
      end else if (take_ckpt_i) begin
         bhr_sv <= bhr_q;
         ptr_sv <= ptr_q;
      end
   end

   for (genvar e = 0; e < RAS_DEPTH; e++) begin : g_ent
      logic [RA_W-1:0] ent_q, ent_sv;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_q <= '0;
         end else if (restore_i) begin
            ent_q <= ent_sv;
         end else if (we_i) begin
            ent_q <= stk_i[e*RA_W +: RA_W];
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_sv <= '0;
         end else if (take_ckpt_i) begin
            ent_sv <= ent_q;
         end
      end

      assign stk_o[e*RA_W +: RA_W] = ent_q;
   end

   assign bhr_o = bhr_q;
   assign ptr_o = ptr_q;

endmodule

// File: rtl/rahead_read_port.sv
module rahead_read_port #(
   parameter int unsigned NREGS = 32,
   parameter int unsigned XLEN  = 32,
   localparam int unsigned IDX_W = rahead_pkg::idx_width(NREGS)
) (
   input  logic [XLEN-1:0]  val_i [NREGS],
   input  logic [NREGS-1:0] inv_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic [XLEN-1:0]  data_o,
   output logic             inv_o
);

   assign data_o = val_i[idx_i];
   assign inv_o  = inv_i[idx_i];

endmodule

// File: rtl/rahead_regfile.sv
module rahead_regfile
   import rahead_pkg::*;
#(
   parameter int unsigned NREGS     = 32,
   parameter int unsigned XLEN      = 32,
   parameter int unsigned BHR_W     = 16,
   parameter int unsigned RA_W      = 32,
   parameter int unsigned RAS_DEPTH = 4,
   parameter bit          HARD_ZERO = 1'b1,
   localparam int unsigned IDX_W    = idx_width(NREGS),
   localparam int unsigned PTR_W    = idx_width(RAS_DEPTH),
   localparam int unsigned STK_W    = RAS_DEPTH * RA_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd0_idx,
   output logic [XLEN-1:0]  rd0_data,
   output logic             rd0_inv,
   input  logic [IDX_W-1:0] rd1_idx,
   output logic [XLEN-1:0]  rd1_data,
   output logic             rd1_inv,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [XLEN-1:0]  wr_data,
   input  logic             wr_src0_inv,
   input  logic             wr_src1_inv,
   input  logic             wr_miss,
   input  logic             ra_enter,
   input  logic             ra_exit,
   output logic             in_runahead,
   input  logic             st_we,
   input  logic [BHR_W-1:0] st_bhr_in,
   input  logic [STK_W-1:0] st_ras_in,
   input  logic [PTR_W-1:0] st_top_in,
   output logic [BHR_W-1:0] st_bhr,
   output logic [STK_W-1:0] st_ras,
   output logic [PTR_W-1:0] st_top
);

   if ((NREGS < 2) || ((NREGS & (NREGS - 1)) != 0)) begin : g_bad_nregs
      $error("NREGS must be a power of two, at least 2");
   end
   if ((XLEN == 0) || (BHR_W == 0) || (RA_W == 0)) begin : g_bad_width
      $error("widths must be non-zero");
   end
   if ((RAS_DEPTH < 1) || ((RAS_DEPTH & (RAS_DEPTH - 1)) != 0)) begin : g_bad_ras
      $error("RAS_DEPTH must be a power of two, at least 1");
   end

   logic            spec;
   logic            take_ckpt;
   logic            restore;
   logic            wr_poison;
   logic [XLEN-1:0] rf_val [NREGS];
   logic [NREGS-1:0] rf_inv;

   rahead_mode_ctl u_mode (
      .clk         (clk),
      .rst_n       (rst_n),
      .enter_i     (ra_enter),
      .exit_i      (ra_exit),
      .spec_o      (spec),
      .take_ckpt_o (take_ckpt),
      .restore_o   (restore)
   );

   assign wr_poison = result_poison(wr_src0_inv, wr_src1_inv, wr_miss, spec);

   rahead_reg_bank #(
      .NREGS     (NREGS),
      .XLEN      (XLEN),
      .HARD_ZERO (HARD_ZERO)
   ) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .we_i        (wr_en),
      .widx_i      (wr_idx),
      .wdata_i     (wr_data),
      .winv_i      (wr_poison),
      .take_ckpt_i (take_ckpt),
      .restore_i   (restore),
      .val_o       (rf_val),
      .inv_o       (rf_inv)
   );

   rahead_spec_state #(
      .BHR_W     (BHR_W),
      .RA_W      (RA_W),
      .RAS_DEPTH (RAS_DEPTH)
   ) u_state (
      .clk         (clk),
      .rst_n       (rst_n),
      .we_i        (st_we),
      .bhr_i       (st_bhr_in),
      .stk_i       (st_ras_in),
      .ptr_i       (st_top_in),
      .take_ckpt_i (take_ckpt),
      .restore_i   (restore),
      .bhr_o       (st_bhr),
      .stk_o       (st_ras),
      .ptr_o       (st_top)
   );

   logic [IDX_W-1:0] rp_idx  [2];
   logic [XLEN-1:0]  rp_data [2];
   logic             rp_inv  [2];

   assign rp_idx[0] = rd0_idx;
   assign rp_idx[1] = rd1_idx;

   for (genvar p = 0; p < 2; p++) begin : g_rport
      rahead_read_port #(
         .NREGS (NREGS),
         .XLEN  (XLEN)
      ) u_rp (
         .val_i  (rf_val),
         .inv_i  (rf_inv),
         .idx_i  (rp_idx[p]),
         .data_o (rp_data[p]),
         .inv_o  (rp_inv[p])
      );
   end

   assign rd0_data    = rp_data[0];
   assign rd0_inv     = rp_inv[0];
   assign rd1_data    = rp_data[1];
   assign rd1_inv     = rp_inv[1];
   assign in_runahead = spec;

endmodule

// File: rtl/rahead_regfile_chk.sv
module rahead_regfile_chk #(
   parameter int unsigned NREGS     = 32,
   parameter int unsigned XLEN      = 32,
   parameter int unsigned BHR_W     = 16,
   parameter int unsigned RA_W      = 32,
   parameter int unsigned RAS_DEPTH = 4,
   parameter bit          HARD_ZERO = 1'b1,
   localparam int unsigned IDX_W    = rahead_pkg::idx_width(NREGS),
   localparam int unsigned PTR_W    = rahead_pkg::idx_width(RAS_DEPTH),
   localparam int unsigned STK_W    = RAS_DEPTH * RA_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic [IDX_W-1:0] rd0_idx,
   input logic [XLEN-1:0]  rd0_data,
   input logic             rd0_inv,
   input logic             rd1_inv,
   input logic             wr_en,
   input logic [IDX_W-1:0] wr_idx,
   input logic             wr_src0_inv,
   input logic             wr_src1_inv,
   input logic             wr_miss,
   input logic             ra_enter,
   input logic             ra_exit,
   input logic             in_runahead,
   input logic             st_we,
   input logic [BHR_W-1:0] st_bhr_in,
   input logic [BHR_W-1:0] st_bhr
);

   // R2: index zero is always clean zero
   p_zero_reg_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (HARD_ZERO && rd0_idx == '0) |-> (rd0_data == '0 && !rd0_inv));

   // R3: nothing is poisoned outside runahead
   p_clean_normal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !in_runahead |-> (!rd0_inv && !rd1_inv));

   // R4: an enter in normal mode starts runahead
   p_enter_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ra_enter && !in_runahead) |=> in_runahead);

   // R5: a poisoned producer poisons its destination
   p_poison_flow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && in_runahead && !ra_exit && wr_idx != '0
       && (wr_src0_inv || wr_src1_inv || wr_miss))
      |=> (rd0_idx != $past(wr_idx)) || rd0_inv);

   // R7: exit leaves runahead with no poison visible
   p_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ra_exit && in_runahead) |=> (!in_runahead && !rd0_inv && !rd1_inv));

   // R9: runahead persists until an exit strobe
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_runahead && !ra_exit) |=> in_runahead);

   // R10: a state write outside an exit cycle lands
   p_state_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_we && !(ra_exit && in_runahead)) |=> (st_bhr == $past(st_bhr_in)));

endmodule

bind rahead_regfile rahead_regfile_chk #(
   .NREGS     (NREGS),
   .XLEN      (XLEN),
   .BHR_W     (BHR_W),
   .RA_W      (RA_W),
   .RAS_DEPTH (RAS_DEPTH),
   .HARD_ZERO (HARD_ZERO)
) u_chk (.*);

// File: tb/rahead_regfile_tb_top.sv
module rahead_regfile_tb_top;

   localparam int unsigned XLEN  = 32;
   localparam int unsigned BHR_W = 16;
   localparam int unsigned STK_W = 128;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [4:0]        rd0_idx = '0, rd1_idx = '0, wr_idx = '0;
   logic [XLEN-1:0]   rd0_data, rd1_data, wr_data = '0;
   logic              rd0_inv, rd1_inv;
   logic              wr_en = 1'b0, wr_src0_inv = 1'b0, wr_src1_inv = 1'b0, wr_miss = 1'b0;
   logic              ra_enter = 1'b0, ra_exit = 1'b0, in_runahead;
   logic              st_we = 1'b0;
   logic [BHR_W-1:0]  st_bhr_in = '0, st_bhr;
   logic [STK_W-1:0]  st_ras_in = '0, st_ras;
   logic [1:0]        st_top_in = '0, st_top;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   localparam logic [31:0] VA = 32'h1111_AAAA;
   localparam logic [31:0] VB = 32'h2222_BBBB;
   localparam logic [31:0] VC = 32'hCCCC_0003;
   localparam logic [15:0] H1 = 16'h00A5;
   localparam logic [15:0] H2 = 16'h5A5A;
   localparam logic [15:0] H3 = 16'h0F0F;
   localparam logic [15:0] H4 = 16'hBEEF;
   localparam logic [127:0] S1 = {32'h4000_0010, 32'h4000_0020, 32'h4000_0030, 32'h4000_0040};
   localparam logic [127:0] S2 = {32'h9999_0001, 32'h9999_0002, 32'h9999_0003, 32'h9999_0004};

   always #10 clk = ~clk;

   rahead_regfile dut_i (
      .clk(clk), .rst_n(rst_n),
      .rd0_idx(rd0_idx), .rd0_data(rd0_data), .rd0_inv(rd0_inv),
      .rd1_idx(rd1_idx), .rd1_data(rd1_data), .rd1_inv(rd1_inv),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .wr_src0_inv(wr_src0_inv), .wr_src1_inv(wr_src1_inv), .wr_miss(wr_miss),
      .ra_enter(ra_enter), .ra_exit(ra_exit), .in_runahead(in_runahead),
      .st_we(st_we), .st_bhr_in(st_bhr_in), .st_ras_in(st_ras_in), .st_top_in(st_top_in),
      .st_bhr(st_bhr), .st_ras(st_ras), .st_top(st_top)
   );

   task automatic check(input string req, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic idle();
      wr_en = 0; wr_src0_inv = 0; wr_src1_inv = 0; wr_miss = 0;
      ra_enter = 0; ra_exit = 0; st_we = 0;
   endtask

   task automatic wr(input logic [4:0] idx, input logic [31:0] d,
                     input logic s0, input logic s1, input logic m);
      wr_en = 1; wr_idx = idx; wr_data = d;
      wr_src0_inv = s0; wr_src1_inv = s1; wr_miss = m;
   endtask

   task automatic rd(input logic [4:0] idx, output logic [31:0] d, output logic inv);
      rd0_idx = idx;
      #1;
      d = rd0_data; inv = rd0_inv;
   endtask

   task automatic t_reset();
      logic [31:0] d; logic v;
      check("R1", "mode", in_runahead, 0);
      rd(5'd9, d, v);
      check("R1", "reg9", d, 0);
      check("R1", "reg9 poison", v, 0);
      check("R1", "bhr", st_bhr, 0);
      check("R1", "ras", st_ras, 0);
      check("R1", "top", st_top, 0);
   endtask

   task automatic t_normal_write();
      wr(5'd5, VA, 1, 1, 1); step();
      wr(5'd9, VB, 0, 0, 1); step();
      idle();
      rd0_idx = 5'd5; rd1_idx = 5'd9; #1;
      check("R3", "port0 reg5", rd0_data, VA);
      check("R3", "port0 poison normal", rd0_inv, 0);
      check("R3", "port1 reg9", rd1_data, VB);
      check("R3", "port1 poison normal", rd1_inv, 0);
   endtask

   task automatic t_zero_reg();
      wr(5'd0, 32'hFFFF_FFFF, 0, 0, 0); step(); idle();
      rd0_idx = 5'd0; rd1_idx = 5'd0; #1;
      check("R2", "reg0 port0", rd0_data, 0);
      check("R2", "reg0 port1", rd1_data, 0);
   endtask

   task automatic t_state_write();
      st_we = 1; st_bhr_in = H1; st_ras_in = S1; st_top_in = 2'd2; step(); idle();
      check("R10", "bhr", st_bhr, H1);
      check("R10", "ras", st_ras, S1);
      check("R10", "top", st_top, 2);
   endtask

   task automatic t_enter();
      ra_enter = 1; wr(5'd5, VC, 0, 0, 0);
      st_we = 1; st_bhr_in = H2; st_ras_in = S2; st_top_in = 2'd3;
      step(); idle();
      check("R4", "mode after enter", in_runahead, 1);
      rd0_idx = 5'd5; #1;
      check("R4", "same-cycle write lands", rd0_data, VC);
      check("R4", "same-cycle state write lands", st_bhr, H2);
   endtask

   task automatic t_poison();
      logic [31:0] d; logic v;
      wr(5'd7, 32'h7, 0, 0, 1); step();
      wr(5'd8, 32'h8, 1, 0, 0); step();
      wr(5'd11, 32'hB, 0, 1, 0); step();
      wr(5'd9, 32'h99, 0, 0, 0); step();
      wr(5'd0, 32'h5, 1, 1, 1); step();
      idle();
      rd(5'd7, d, v);  check("R5", "miss poisons", v, 1);
      check("R5", "miss data", d, 32'h7);
      rd(5'd8, d, v);  check("R5", "src0 poisons", v, 1);
      rd(5'd11, d, v); check("R5", "src1 poisons", v, 1);
      rd(5'd9, d, v);  check("R6", "clean write clean", v, 0);
      rd(5'd0, d, v);  check("R2", "reg0 in runahead", {d, v}, 0);
      wr(5'd7, 32'h77, 0, 0, 0); step(); idle();
      rd(5'd7, d, v);  check("R6", "poison cleared", v, 0);
   endtask

   task automatic t_reenter();
      wr(5'd10, 32'h1010, 0, 0, 0);
      st_we = 1; st_bhr_in = H3; st_ras_in = S2; st_top_in = 2'd1;
      step(); idle();
      ra_enter = 1; step(); idle();
      check("R9", "enter in runahead keeps mode", in_runahead, 1);
   endtask

   task automatic t_exit();
      logic [31:0] d; logic v;
      ra_exit = 1; wr(5'd10, 32'hDEAD_0010, 1, 0, 0);
      st_we = 1; st_bhr_in = H4; st_ras_in = S2; st_top_in = 2'd0;
      step(); idle();
      check("R7", "mode after exit", in_runahead, 0);
      rd(5'd5, d, v);  check("R7", "reg5 restored pre-enter", d, VA);
      rd(5'd9, d, v);  check("R7", "reg9 restored", d, VB);
      rd(5'd7, d, v);  check("R7", "reg7 restored clean", {d, v}, 0);
      rd(5'd8, d, v);  check("R7", "reg8 poison cleared", v, 0);
      rd(5'd10, d, v); check("R8", "exit-cycle write dropped", d, 0);
      check("R7", "bhr restored", st_bhr, H1);
      check("R7", "ras restored", st_ras, S1);
      check("R8", "top restored not written", st_top, 2);
   endtask

   task automatic t_exit_normal();
      logic [31:0] d; logic v;
      ra_exit = 1; step(); idle();
      check("R9", "exit in normal mode", in_runahead, 0);
      rd(5'd5, d, v); check("R9", "reg5 untouched", d, VA);
      check("R9", "bhr untouched", st_bhr, H1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      #1;
      t_reset();
      t_normal_write();
      t_zero_reg();
      t_state_write();
      t_enter();
      t_poison();
      t_reenter();
      t_exit();
      t_exit_normal();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule